// File: doc/BRIEF.md
# Frame-Counted SPI Master

This block is a serial peripheral master that shifts a host word out on MOSI, most significant bit first, while it collects the same number of bits from MISO. The host starts a transfer of 1, 8 or 16 bits with a one-cycle strobe. It waits for a done pulse, and the received bits come back on `rx_o`.

Chip select does not follow single transfers. A frame counter counts the bits clocked since chip select went active and releases it only when a programmable frame length is reached. One frame can therefore cover several host transfers, for example when a chain of shift-register slaves must all be filled before they latch together. The release happens while SCLK still sits at its active level after the last bit. SCLK returns to idle only half a period later. This order suits slaves that latch on the chip-select edge.

Clock polarity, clock phase, chip-select polarity, frame length and the SCLK half-period divider are set through a single configuration write strobe. The same write also resets the framing state.

Top module: `spi_chain_master`

## Requirements
- R1: After reset, and in the cycle after any `cfg_we_i` pulse, the block is in a known idle state. Chip select is inactive, SCLK is at the idle level, `busy_o` is low and the frame bit count is zero. A transfer that is in progress is abandoned without a done pulse.
- R2: `cfg_mode_i[1]` is clock polarity and sets the SCLK idle level. `cfg_mode_i[0]` is clock phase. The modes are 0 (idle low, PHA 0), 1 (idle low, PHA 1), 2 (idle high, PHA 0) and 3 (idle high, PHA 1). Mode 0 is the reset default.
- R3: MOSI carries the tx bits most significant first. With PHA 0, each bit is on MOSI from before its leading SCLK edge. With PHA 1, each bit appears at its leading edge. In both cases the bit is valid at the leading edge.
- R4: MISO is captured on the leading edge when PHA is 0 and on the trailing edge when PHA is 1. The first captured bit is the most significant of the result. `rx_o` is right-aligned, its unused upper bits are zero, and it is valid when `done_o` is high.
- R5: `size_i` = 0 transfers 1 bit, 1 transfers 8 bits (`tx_i[7:0]`), and 2 or 3 transfers 16 bits. The number of leading SCLK edges equals that size.
- R6: With `cfg_cs_pol_i` = 0, chip select is active-low. With 1 it is active-high. Active-low is the reset default.
- R7: Chip select becomes active while SCLK is idle, before the first edge of a frame. It stays active across transfer boundaries and is released after exactly frame-length leading edges; the reset frame length is 16. No leading edge occurs while chip select is inactive.
- R8: Chip select is released while SCLK is at its active level, and SCLK stays active for one more half-period before it returns to idle. If the transfer still has bits to send, chip select becomes active again as SCLK returns to idle, and a new frame begins.
- R9: A frame length of 0 disables the release. Chip select then stays active across transfers until the next configuration write.
- R10: Each SCLK half-period lasts `cfg_div_i` system clocks, and 0 counts as 1; the reset value is 1. Within one transfer, consecutive leading edges that have no release between them are 2×div clocks apart.
- R11: `busy_o` rises in the cycle after an accepted start and falls with the one-cycle `done_o` pulse. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe; also resets framing |
| cfg_mode_i | input | 2 | {POL, PHA} |
| cfg_cs_pol_i | input | 1 | Chip-select active level |
| cfg_frame_len_i | input | FLEN_W | Bits per chip-select period, 0 = never release |
| cfg_div_i | input | DIV_W | System clocks per SCLK half-period |
| start_i | input | 1 | Transfer start strobe |
| size_i | input | 2 | Transfer size select |
| tx_i | input | 16 | Data to send, right-aligned |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rx_o | output | 16 | Received data, right-aligned |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_o | output | 1 | Chip select |

## Verification
The bench sweeps all four modes, both chip-select levels and two divider values. Frame lengths are chosen so that a frame ends exactly at a transfer boundary, in the middle of a 16-bit transfer, and across three 1-bit transfers. A design that releases chip select after every transfer, or counts the frame off by one, shows a wrong edge count at the release. A design that drops chip select after SCLK has already returned to idle is caught at the release edge. A wrong MISO capture edge for PHA 1 would shift the received word by one bit. The bench also covers a frame length of 0, a divider of 0, a start pulsed while busy and the 3 size code. A design that truncates the held frame, stalls the divider, restarts on the second strobe or sends 8 bits for code 3 changes the edge count or the data.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;
  localparam int WORD_W = 16;
  localparam int BITS_W = $clog2(WORD_W + 1);

  typedef enum logic [1:0] {
    S_IDLE    = 2'd0,
    S_SETUP   = 2'd1,
    S_ACTIVE  = 2'd2,
    S_RELEASE = 2'd3
  } sp_state_e;

  function automatic logic [BITS_W-1:0] size_to_bits(input logic [1:0] sel);
    case (sel)
      2'd0:    size_to_bits = BITS_W'(1);
      2'd1:    size_to_bits = BITS_W'(8);
      default: size_to_bits = BITS_W'(WORD_W);
    endcase
  endfunction
endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_eff;

  assign div_eff = (div_i == '0) ? DIV_W'(1) : div_i;
  assign tick_o  = run_i && (cnt_q == div_eff - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_in_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < div_eff));
endmodule

// File: rtl/spi_frame_ctl.sv
module spi_frame_ctl #(
  parameter int FLEN_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              bit_i,
  input  logic [FLEN_W-1:0] len_i,
  output logic              last_o
);
  logic [FLEN_W-1:0] cnt_q;

  // len 0: never flags a last bit, frame held open
  assign last_o = (len_i != '0) && (cnt_q == len_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (bit_i)  cnt_q <= last_o ? '0 : cnt_q + 1'b1;
  end

  p_cnt_below_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_i != '0) |-> (cnt_q < len_i));
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  input  logic         sample_i,
  input  logic         miso_i,
  output logic         msb_o,
  output logic         hold_o,
  output logic [W-1:0] rx_o
);
  logic [W-1:0] tx_q;
  logic [W-1:0] rx_q;
  logic         hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q   <= '0;
      rx_q   <= '0;
      hold_q <= 1'b0;
    end else if (load_i) begin
      tx_q <= load_val_i;
      rx_q <= '0;
    end else begin
      if (shift_i) begin
        tx_q   <= tx_q << 1;
        hold_q <= tx_q[W-1];
      end
      if (sample_i) rx_q <= {rx_q[W-2:0], miso_i};
    end
  end

  assign msb_o  = tx_q[W-1];
  assign hold_o = hold_q;
  assign rx_o   = rx_q;
endmodule

// File: rtl/spi_chain_master.sv
module spi_chain_master
  import spi_chain_pkg::*;
#(
  parameter int                DIV_W    = 8,
  parameter int                FLEN_W   = 16,
  parameter logic [DIV_W-1:0]  DEF_DIV  = 1,
  parameter logic [FLEN_W-1:0] DEF_FLEN = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_mode_i,
  input  logic              cfg_cs_pol_i,
  input  logic [FLEN_W-1:0] cfg_frame_len_i,
  input  logic [DIV_W-1:0]  cfg_div_i,
  input  logic              start_i,
  input  logic [1:0]        size_i,
  input  logic [15:0]       tx_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [15:0]       rx_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              cs_o
);
  sp_state_e         state_q;
  logic [1:0]        mode_q;
  logic              cspol_q;
  logic [FLEN_W-1:0] flen_q;
  logic [DIV_W-1:0]  div_q;
  logic [BITS_W-1:0] left_q;
  logic              cs_act_q;
  logic              done_q;

  logic              tick, frame_last, pha, cpol;
  logic              start_ok, setup_end, active_end, rel_end;
  logic              do_sample, do_shift, msb, hold;
  logic [BITS_W-1:0] n_bits;
  logic [WORD_W-1:0] aligned;

  assign pha        = mode_q[0];
  assign cpol       = mode_q[1];
  assign start_ok   = start_i && (state_q == S_IDLE) && !cfg_we_i;
  assign n_bits     = size_to_bits(size_i);
  assign aligned    = tx_i << (BITS_W'(WORD_W) - n_bits);
  assign setup_end  = (state_q == S_SETUP)   && tick;
  assign active_end = (state_q == S_ACTIVE)  && tick;
  assign rel_end    = (state_q == S_RELEASE) && tick;
  assign do_sample  = (setup_end && !pha) || (active_end && pha);
  // shift on trailing edge; a releasing bit shifts after its extra half-period
  assign do_shift   = (active_end && !frame_last) || rel_end;

  spi_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (state_q != S_IDLE),
    .div_i (div_q),
    .tick_o(tick)
  );

  spi_frame_ctl #(.FLEN_W(FLEN_W)) u_frame (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cfg_we_i),
    .bit_i (active_end && !cfg_we_i),
    .len_i (flen_q),
    .last_o(frame_last)
  );

  spi_shifter #(.W(WORD_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (start_ok),
    .load_val_i(aligned),
    .shift_i   (do_shift),
    .sample_i  (do_sample),
    .miso_i    (miso_i),
    .msb_o     (msb),
    .hold_o    (hold),
    .rx_o      (rx_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      mode_q   <= 2'd0;
      cspol_q  <= 1'b0;
      flen_q   <= DEF_FLEN;
      div_q    <= DEF_DIV;
      left_q   <= '0;
      cs_act_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (cfg_we_i) begin
        mode_q   <= cfg_mode_i;
        cspol_q  <= cfg_cs_pol_i;
        flen_q   <= cfg_frame_len_i;
        div_q    <= cfg_div_i;
        state_q  <= S_IDLE;
        left_q   <= '0;
        cs_act_q <= 1'b0;
      end else begin
        unique case (state_q)
          S_IDLE: if (start_ok) begin
            state_q  <= S_SETUP;
            cs_act_q <= 1'b1;
            left_q   <= n_bits;
          end
          S_SETUP: if (tick) state_q <= S_ACTIVE;
          S_ACTIVE: if (tick) begin
            left_q <= left_q - 1'b1;
            if (frame_last) begin
              state_q  <= S_RELEASE;
              cs_act_q <= 1'b0;
            end else if (left_q == BITS_W'(1)) begin
              state_q <= S_IDLE;
              done_q  <= 1'b1;
            end else begin
              state_q <= S_SETUP;
            end
          end
          S_RELEASE: if (tick) begin
            if (left_q == '0) begin
              state_q <= S_IDLE;
              done_q  <= 1'b1;
            end else begin
              state_q  <= S_SETUP;
              cs_act_q <= 1'b1;
            end
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  assign sclk_o = cpol ^ ((state_q == S_ACTIVE) || (state_q == S_RELEASE));
  assign mosi_o = ((state_q == S_IDLE) || ((state_q == S_SETUP) && pha)) ? hold : msb;
  assign cs_o   = cspol_q ? cs_act_q : !cs_act_q;
  assign busy_o = (state_q != S_IDLE);
  assign done_o = done_q;

  p_cs_release_clk_active_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_act_q && $past(cs_act_q) && !$past(cfg_we_i)) |-> (sclk_o != cpol));
  p_edge_inside_frame_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(sclk_o) && (sclk_o != cpol) && !$past(cfg_we_i) |-> cs_act_q);
  p_done_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_start_accepted_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !cfg_we_i) |=> busy_o);
  p_done_all_bits_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (left_q == '0) && !busy_o);
endmodule

// File: tb/spi_chain_master_test.sv
module spi_chain_master_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_mode_i = 2'd0;
  logic        cfg_cs_pol_i = 1'b0;
  logic [15:0] cfg_frame_len_i = 16'd16;
  logic [7:0]  cfg_div_i = 8'd1;
  logic        start_i = 1'b0;
  logic [1:0]  size_i = 2'd0;
  logic [15:0] tx_i = '0;
  logic        busy_o, done_o, sclk_o, mosi_o, cs_o;
  logic [15:0] rx_o;
  logic        miso_i = 1'b0;

  always #5 clk = ~clk;

  spi_chain_master uut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_mode_i(cfg_mode_i),
    .cfg_cs_pol_i(cfg_cs_pol_i), .cfg_frame_len_i(cfg_frame_len_i), .cfg_div_i(cfg_div_i),
    .start_i(start_i), .size_i(size_i), .tx_i(tx_i), .busy_o(busy_o), .done_o(done_o),
    .rx_o(rx_o), .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso_i), .cs_o(cs_o)
  );

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;
  logic [1:0] b_mode = 0;
  logic b_pol = 0;
  int b_len = 16, b_div = 1;
  bit mon_en = 0, prev_sclk, prev_on, prev_mosi, have_prev = 0;
  int edge_cnt = 0, fr_cnt = 0, last_edge = 0;
  logic cap [0:4095];

  function automatic logic fbit(input int n);
    return logic'((n % 3) == 0) ^ logic'((n >> 2) & 1);
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // bus monitor and MISO responder
  always @(negedge clk) begin
    bit on, cpol;
    int deff;
    cyc++;
    cpol = b_mode[1];
    on   = (cs_o == b_pol);
    deff = (b_div == 0) ? 1 : b_div;
    if (!mon_en) begin
      have_prev = 0;
    end else begin
      if (on && !prev_on) begin
        chk(sclk_o == cpol, "R7", "sclk idle at select", sclk_o, cpol);
        fr_cnt = 0;
      end
      if (!on && prev_on) begin
        chk(sclk_o != cpol, "R8", "sclk active at release", sclk_o, !cpol);
        chk(fr_cnt == b_len, "R7", "edges per frame", fr_cnt, b_len);
        have_prev = 0;
      end
      if (sclk_o != prev_sclk && sclk_o != cpol) begin
        chk(on, "R7", "edge with select inactive", on, 1);
        if (!b_mode[0]) chk(prev_mosi == mosi_o, "R3", "mosi stable before edge", prev_mosi, mosi_o);
        if (have_prev) chk(cyc - last_edge == 2 * deff, "R10", "sclk period", cyc - last_edge, 2 * deff);
        cap[edge_cnt % 4096] = mosi_o;
        edge_cnt++;
        fr_cnt++;
        have_prev = 1;
        last_edge = cyc;
      end
      if (done_o) have_prev = 0;
    end
    prev_sclk = sclk_o;
    prev_on   = on;
    prev_mosi = mosi_o;
    miso_i    = fbit(edge_cnt);
  end

  task automatic cfg(input logic [1:0] m, input logic p, input int len, input int dv);
    mon_en = 0;
    @(negedge clk);
    cfg_we_i = 1; cfg_mode_i = m; cfg_cs_pol_i = p;
    cfg_frame_len_i = 16'(len); cfg_div_i = 8'(dv);
    @(negedge clk);
    cfg_we_i = 0;
    b_mode = m; b_pol = p; b_len = len; b_div = dv;
    chk(sclk_o == m[1], "R2", "idle sclk after cfg", sclk_o, m[1]);
    chk(cs_o == !p, "R6", "inactive select after cfg", cs_o, !p);
    chk(!busy_o, "R1", "idle after cfg", busy_o, 0);
    @(negedge clk);
    mon_en = 1;
  endtask

  task automatic xfer(input logic [1:0] sz, input logic [15:0] tx, input bit poke);
    int n, s;
    logic [15:0] exp_rx;
    int mism;
    n = (sz == 0) ? 1 : (sz == 1) ? 8 : 16;
    @(negedge clk);
    chk(!busy_o, "R11", "idle before start", busy_o, 0);
    s = edge_cnt;
    start_i = 1; size_i = sz; tx_i = tx;
    @(negedge clk);
    start_i = 0;
    chk(busy_o, "R11", "busy after start", busy_o, 1);
    if (poke && n == 16) begin
      repeat (3) @(negedge clk);
      start_i = 1; size_i = 2'd0; tx_i = ~tx;
      @(negedge clk);
      start_i = 0;
    end
    while (!done_o) @(negedge clk);
    chk(edge_cnt - s == n, "R5", "edges per transfer", edge_cnt - s, n);
    exp_rx = '0;
    for (int j = 0; j < n; j++) exp_rx = {exp_rx[14:0], fbit(s + j + int'(b_mode[0]))};
    chk(rx_o == exp_rx, "R4", "received word", rx_o, exp_rx);
    mism = 0;
    for (int j = 0; j < n; j++) if (cap[(s + j) % 4096] !== tx[n-1-j]) mism++;
    chk(mism == 0, "R3", "mosi bits msb first", mism, 0);
    @(negedge clk);
    chk(!done_o && !busy_o, "R11", "done single cycle", done_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_o == 1'b1, "R6", "reset select level", cs_o, 1);
    chk(sclk_o == 1'b0, "R1", "reset sclk level", sclk_o, 0);
    chk(!busy_o && !done_o, "R1", "reset idle", busy_o, 0);
    rst_ni = 1;
    @(negedge clk);
    mon_en = 1;
    xfer(2'd2, 16'hC35A, 0);
    chk(cs_o == 1'b1, "R7", "default frame of 16 released", cs_o, 1);
    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 2; p++) begin
        for (int d = 0; d < 2; d++) begin
          logic [15:0] t;
          int dv;
          dv = (d == 0) ? 1 : 3;
          t = 16'hA5C3 ^ 16'((m * 8 + p * 4 + d) * 16'h1357);
          cfg(2'(m), 1'(p), 16, dv);
          xfer(2'd2, t, 0);
          cfg(2'(m), 1'(p), 24, dv);
          xfer(2'd1, ~t, 0);
          chk(cs_o == 1'(p), "R7", "select held between transfers", cs_o, p);
          xfer(2'd2, {t[7:0], t[15:8]}, 1);
          chk(cs_o == !1'(p), "R7", "select released after 24", cs_o, !p);
          cfg(2'(m), 1'(p), 12, dv);
          xfer(2'd2, t ^ 16'h0FF0, 0);
          chk(cs_o == 1'(p), "R8", "select reopened mid transfer", cs_o, p);
          xfer(2'd1, t, 0);
          cfg(2'(m), 1'(p), 3, dv);
          xfer(2'd0, {15'd0, t[0]}, 0);
          xfer(2'd0, {15'd0, ~t[0]}, 0);
          xfer(2'd0, {15'd0, t[3]}, 0);
          chk(cs_o == !1'(p), "R7", "select released after 3 single bits", cs_o, !p);
        end
      end
    end
    cfg(2'd1, 1'b0, 0, 2);
    xfer(2'd2, 16'h1234, 0);
    xfer(2'd2, 16'hFEDC, 0);
    repeat (20) @(negedge clk);
    chk(cs_o == 1'b0, "R9", "zero length holds select", cs_o, 0);
    cfg(2'd1, 1'b0, 16, 2);
    chk(cs_o == 1'b1, "R9", "cfg write releases held select", cs_o, 1);
    cfg(2'd0, 1'b1, 8, 0);
    xfer(2'd1, 16'h0096, 0);
    cfg(2'd3, 1'b0, 16, 2);
    xfer(2'd3, 16'h6E19, 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R11 watchdog act=%0d exp=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule